// File: doc/BRIEF.md
# Single-Clock FIFO with Run-Time Almost Flags

This block is a synchronous first-in first-out buffer built around one 4,608-bit storage array. At build time the parameter `CFG_SEL` picks one of five shapes for the array: 256 words of 18 bits, 512 of 9, 1024 of 4, 2048 of 2, or 4096 of 1. Two internal pointer counters produce all the array addresses, so the surrounding logic only presents data and requests.

Data enters through a valid/ready handshake. The block raises `in_ready` whenever it has a free slot. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. If `in_valid` is high while `in_ready` is low, that word is dropped and nothing inside the block changes, so a producer that must not lose data has to hold its word until `in_ready` returns.

Data leaves on request. A high `pop_req` while the buffer holds data removes the oldest word. That word appears on `out_data` one clock later, marked by a one-cycle pulse on `out_valid`. The consumer cannot apply back-pressure on this side, so it must take each word in the cycle it is marked.

Two thresholds, which may change at any time, drive the almost-full and almost-empty flags.

Top module: `tuned_fifo`

## Requirements
- R1: `in_ready` is high exactly when the buffer is not full. A word is accepted on an edge where `in_valid` and `in_ready` are both high.
- R2: A `pop_req` on an edge where the buffer is not empty removes the oldest word. `out_valid` is then high for one cycle after that edge, and `out_data` carries that word. Words leave in the order they were accepted.
- R3: A word offered while the buffer is full is dropped. The occupancy does not change, and the dropped word never appears on `out_data`.
- R4: A `pop_req` while the buffer is empty is ignored. `out_valid` stays low and `empty` stays high.
- R5: `full` is high exactly when the occupancy equals the depth. `empty` is high exactly when the occupancy is zero.
- R6: `afull` is high exactly when the occupancy is greater than or equal to `af_thr`. `af_thr` must lie in 1..depth.
- R7: `aempty` is high exactly when the occupancy is less than or equal to `ae_thr`.
- R8: An accepted push and an accepted pop on the same edge leave the occupancy unchanged.
- R9: While `rst` is high at a clock edge, the buffer is emptied. After that edge `empty` and `aempty` are high, and `full`, `afull` and `out_valid` are low.
- R10: Order is preserved when the pointers wrap past the last address. Each pointer carries one wrap bit beyond the address, so full and empty are distinguished when the addresses match.
- R11: `CFG_SEL` values 0, 1, 2, 3 and 4 give 256x18, 512x9, 1024x4, 2048x2 and 4096x1 respectively. Both the data width and the depth follow this choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Buffer can accept a word |
| in_data | input | DW | Word offered |
| pop_req | input | 1 | Request to remove the oldest word |
| out_valid | output | 1 | `out_data` holds a removed word this cycle |
| out_data | output | DW | Removed word |
| af_thr | input | AW+1 | Almost-full threshold |
| ae_thr | input | AW+1 | Almost-empty threshold |
| full | output | 1 | Occupancy equals depth |
| empty | output | 1 | Occupancy is zero |
| afull | output | 1 | Occupancy at or above `af_thr` |
| aempty | output | 1 | Occupancy at or below `ae_thr` |

## Verification
The hardest case to reach is a full buffer whose pointers have already wrapped. In that state the two addresses are equal and only the wrap bit separates full from empty. The stimulus first moves the pointers a few places with a short push-and-pop burst. It then fills all 256 slots, offers one extra marked word, and drains everything. The scoreboard confirms that the marked word never appears and that the order survives the wrap.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
  localparam int unsigned SHAPE_COUNT = 5;

  function automatic int unsigned shape_width(int unsigned sel);
    case (sel)
      0: return 18;
      1: return 9;
      2: return 4;
      3: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned shape_abits(int unsigned sel);
    return (sel < SHAPE_COUNT) ? 8 + sel : 12;
  endfunction
endpackage

// File: rtl/tfifo_ptr.sv
module tfifo_ptr #(
  parameter int unsigned AW = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adv,
  output logic [AW:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/tfifo_ram.sv
module tfifo_ram #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/tfifo_flags.sv
module tfifo_flags #(
  parameter int unsigned AW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic [AW:0] wptr,
  input  logic [AW:0] rptr,
  input  logic [AW:0] af_thr,
  input  logic [AW:0] ae_thr,
  output logic [AW:0] occ,
  output logic        full,
  output logic        empty,
  output logic        afull,
  output logic        aempty
);
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  always_comb begin
    occ    = wptr - rptr;
    full   = (occ == DEPTH_V);
    empty  = (occ == '0);
    afull  = (occ >= af_thr);
    aempty = (occ <= ae_thr);
  end
endmodule

// File: rtl/tuned_fifo.sv
module tuned_fifo #(
  parameter int unsigned CFG_SEL = 0,
  localparam int unsigned DW = tfifo_pkg::shape_width(CFG_SEL),
  localparam int unsigned AW = tfifo_pkg::shape_abits(CFG_SEL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          pop_req,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic [AW:0]   af_thr,
  input  logic [AW:0]   ae_thr,
  output logic          full,
  output logic          empty,
  output logic          afull,
  output logic          aempty
);
  logic [AW:0] wptr, rptr, occ;
  logic        push_ok, pop_ok;

  assign in_ready = ~full;
  assign push_ok  = in_valid & ~full;
  assign pop_ok   = pop_req & ~empty;

  tfifo_ptr #(.AW(AW)) u_wptr (.clk(clk), .rst(rst), .adv(push_ok), .ptr(wptr));
  tfifo_ptr #(.AW(AW)) u_rptr (.clk(clk), .rst(rst), .adv(pop_ok),  .ptr(rptr));

  tfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(push_ok), .waddr(wptr[AW-1:0]), .wdata(in_data),
    .re(pop_ok), .raddr(rptr[AW-1:0]), .rdata(out_data)
  );

  tfifo_flags #(.AW(AW)) u_flags (
    .wptr(wptr), .rptr(rptr), .af_thr(af_thr), .ae_thr(ae_thr),
    .occ(occ), .full(full), .empty(empty), .afull(afull), .aempty(aempty)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= pop_ok;
  end
endmodule

// File: rtl/tuned_fifo_chk.sv
module tuned_fifo_chk #(
  parameter int unsigned AW = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        pop_req,
  input logic        out_valid,
  input logic        full,
  input logic        empty,
  input logic        afull,
  input logic        aempty,
  input logic [AW:0] occ
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && !pop_req) |=> full);

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_req) |=> !out_valid);

  p_flag_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_read_lat_r2: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !empty) |=> out_valid);

  p_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !full && pop_req && !empty) |=> $stable(occ));

  p_full_afull_r6: assert property (@(posedge clk) disable iff (rst)
    full |-> afull);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (empty && aempty && !full && !out_valid));
endmodule

bind tuned_fifo tuned_fifo_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .pop_req(pop_req),
  .out_valid(out_valid), .full(full), .empty(empty), .afull(afull),
  .aempty(aempty), .occ(occ)
);

// File: tb/tuned_fifo_test.sv
module tuned_fifo_test;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, pop_req = 1'b0;
  logic [17:0] in_data = '0;
  logic [8:0] af_thr = 9'd200, ae_thr = 9'd10;
  logic in_ready, out_valid, full, empty, afull, aempty;
  logic [17:0] out_data;

  logic v2 = 1'b0, p2 = 1'b0;
  logic [3:0] d2 = '0;
  logic [10:0] af2 = 11'd1024, ae2 = 11'd0;
  logic r2, ov2, f2, e2, af2o, ae2o;
  logic [3:0] od2;

  int checks = 0, fails = 0, mcnt = 0;
  logic [17:0] q[$];
  bit vq[$];

  always #2 clk = ~clk;

  tuned_fifo #(.CFG_SEL(0)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pop_req(pop_req), .out_valid(out_valid), .out_data(out_data),
    .af_thr(af_thr), .ae_thr(ae_thr), .full(full), .empty(empty),
    .afull(afull), .aempty(aempty)
  );

  tuned_fifo #(.CFG_SEL(2)) uut2 (
    .clk(clk), .rst(rst), .in_valid(v2), .in_ready(r2), .in_data(d2),
    .pop_req(p2), .out_valid(ov2), .out_data(od2),
    .af_thr(af2), .ae_thr(ae2), .full(f2), .empty(e2),
    .afull(af2o), .aempty(ae2o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_flags();
    check("R5 full", full, mcnt == DEPTH);
    check("R5 empty", empty, mcnt == 0);
    check("R1 in_ready", in_ready, mcnt != DEPTH);
    check("R6 afull", afull, mcnt >= af_thr);
    check("R7 aempty", aempty, mcnt <= ae_thr);
  endtask

  // driver: inputs change on the falling edge; expected items go into the scoreboard
  task automatic step(bit v, logic [17:0] d, bit p);
    bit aw, ar;
    in_valid = v; in_data = d; pop_req = p;
    aw = v && (mcnt < DEPTH);
    ar = p && (mcnt > 0);
    if (aw) q.push_back(d);
    vq.push_back(ar);
    @(posedge clk);
    @(negedge clk);
    mcnt = mcnt + int'(aw) - int'(ar);
    in_valid = 1'b0; pop_req = 1'b0;
    check_flags();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    q.delete(); vq.delete(); mcnt = 0;
  endtask

  // monitor: compares each output pulse against the scoreboard after the edge
  always begin
    @(posedge clk);
    #1;
    if (!rst) begin
      bit ev;
      ev = (vq.size() > 0) ? vq.pop_front() : 1'b0;
      check("R2/R4 out_valid", out_valid, ev);
      if (ev && out_valid) begin
        logic [17:0] e;
        e = q.pop_front();
        check("R2/R10 out_data", out_data, e);
      end
    end
  end

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    q.delete(); vq.delete(); mcnt = 0;
    // R9 reset state
    check("R9 empty", empty, 1);
    check("R9 aempty", aempty, 1);
    check("R9 full", full, 0);
    check("R9 afull", afull, 0);
    check("R9 out_valid", out_valid, 0);

    // R2 ordering with a short burst
    for (int i = 0; i < 5; i++) step(1'b1, 18'(100 + i), 1'b0);
    for (int i = 0; i < 2; i++) step(1'b0, '0, 1'b1);
    // R8 simultaneous push and pop
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 18'(300 + i), 1'b1);
      check("R8 occupancy steady", mcnt, 3);
    end
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1);
    // R4 pop while empty
    step(1'b0, '0, 1'b1);
    check("R4 empty held", empty, 1);

    // R10/R6/R5 fill across the wrap, R3 extra push dropped
    for (int i = 0; i < DEPTH; i++) step(1'b1, 18'(1000 + i), 1'b0);
    check("R5 full at depth", full, 1);
    step(1'b1, 18'h3ffff, 1'b0);
    check("R3 still full", full, 1);
    for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    check("R3 scoreboard drained", q.size(), 0);

    // R6/R7 thresholds changed at run time
    af_thr = 9'd4; ae_thr = 9'd2;
    for (int i = 0; i < 5; i++) step(1'b1, 18'(2000 + i), 1'b0);
    check("R6 afull at 5", afull, 1);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    check("R7 aempty at 3", aempty, 0);
    step(1'b0, '0, 1'b1);
    check("R7 aempty at 2", aempty, 1);

    // R9 reset with data held
    do_reset();
    check("R9 empty after mid reset", empty, 1);
    check("R9 afull after mid reset", afull, 0);
    step(1'b1, 18'h155, 1'b0);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);

    // R11 shape 2 gives 1024 words of 4 bits
    check("R11 width", $bits(od2), 4);
    begin
      int n = 0;
      while (r2 && n < 2000) begin
        v2 = 1'b1; d2 = 4'(n);
        @(posedge clk); @(negedge clk);
        n++;
      end
      v2 = 1'b0;
      check("R11 depth", n, 1024);
      check("R11 full", f2, 1);
    end

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule